// File: doc/BRIEF.md
# Second-Chance Clock Victim Selector

This block chooses which physical frame to give up when a new page has to be brought in. It uses the second-chance clock policy. Each of `FRAMES` frames has a use flag and a modified flag. A hand pointer stays in place from one request to the next. A reference port marks a frame as used, and marks it as modified when the access is a write. When a victim is requested, the hand walks the frames in circular order and examines one frame per clock cycle. It clears every use flag it passes and stops at the first frame whose use flag is already clear.

The request arrives on a valid/ready handshake. `req_ready` is high only while the selector is idle. A request offered while the selector is busy is not accepted: the requester holds `req_valid` until `req_ready` is high. The result leaves on a second valid/ready handshake. `vic_valid` stays high, and `vic_frame` and `vic_dirty` stay unchanged, until the consumer raises `vic_ready`. The reference port has no back-pressure and is taken on every cycle in which `ref_valid` is high.

Top module: `clock_victim_sel`

## Requirements
- R1: After reset every use and modified flag is 0, the hand is at frame 0, `req_ready` is 1 and `vic_valid` is 0.
- R2: A cycle with `ref_valid` high sets the use flag of frame `ref_frame`. If `ref_write` is also high, it sets that frame's modified flag.
- R3: An accepted request starts at the current hand position. Every frame with its use flag set is cleared and passed over, at one frame per clock cycle.
- R4: The first frame found with a clear use flag becomes the victim. With k frames passed over, `vic_valid` rises k+1 clock edges after the edge that accepted the request.
- R5: After a choice the hand points to the frame after the victim, and it wraps from frame `FRAMES`-1 to frame 0.
- R6: `vic_dirty` equals the modified flag the victim held when it was chosen, so only modified victims need a write-back.
- R7: The victim's use and modified flags are cleared when it is chosen.
- R8: When every use flag is set, the victim is the frame at the starting hand position, reached after `FRAMES`+1 sweep cycles.
- R9: When a reference event and a sweep clear hit the same frame in the same cycle, the use flag stays 1.
- R10: While `vic_valid` is 1 and `vic_ready` is 0, `vic_frame` and `vic_dirty` hold their values. `req_ready` is 0 from acceptance until the result is taken.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ref_valid | input | 1 | Reference event strobe |
| ref_frame | input | $clog2(FRAMES) | Frame that was referenced |
| ref_write | input | 1 | The reference was a write |
| req_valid | input | 1 | Victim request offered |
| req_ready | output | 1 | Selector idle, request accepted |
| vic_valid | output | 1 | Victim result available |
| vic_ready | input | 1 | Consumer takes the result |
| vic_frame | output | $clog2(FRAMES) | Chosen victim frame |
| vic_dirty | output | 1 | Victim was modified and needs write-back |

## Verification
The hardest case to reach is a reference event landing on the very frame the hand is clearing in that cycle. The stimulus gets there by counting edges from request acceptance and driving a reference to the frame at the hand in the first sweep cycle. It then sets every other use flag and issues a second request. That request can only end on a full-circle sweep if the contested flag survived. Full-circle sweeps, wrap-around of the hand and dirty victims are reached by preloading chosen reference masks before each request and checking both the victim and the exact sweep latency.

// File: rtl/clock_victim_pkg.sv
package clock_victim_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_SWEEP = 2'd1,
    ST_HOLD  = 2'd2
  } sweep_state_t;
endpackage

// File: rtl/clock_flags.sv
module clock_flags #(
  parameter int FRAMES = 16,
  localparam int IW = $clog2(FRAMES)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              hit_en,
  input  logic [IW-1:0]     hit_idx,
  input  logic              hit_wr,
  input  logic              clr_en,
  input  logic [IW-1:0]     clr_idx,
  input  logic              drop_en,
  output logic [FRAMES-1:0] use_vec,
  output logic [FRAMES-1:0] mod_vec
);
  for (genvar g = 0; g < FRAMES; g++) begin : g_frame
    logic hit_here, clr_here;
    assign hit_here = hit_en && (hit_idx == IW'(g));
    assign clr_here = clr_en && (clr_idx == IW'(g));

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        use_vec[g] <= 1'b0;
        mod_vec[g] <= 1'b0;
      end else begin
        if (hit_here)      use_vec[g] <= 1'b1;  // reference wins over a clear (R9)
        else if (clr_here) use_vec[g] <= 1'b0;
        if (hit_here && hit_wr)      mod_vec[g] <= 1'b1;
        else if (clr_here && drop_en) mod_vec[g] <= 1'b0;
      end
    end
  end

  // R2: a reference leaves the frame's use flag set
  a_r2_ref_sets_use: assert property (@(posedge clk) disable iff (!rst_n)
    hit_en |=> use_vec[$past(hit_idx)]);

  // R2: a write reference leaves the modified flag set
  a_r2_write_sets_mod: assert property (@(posedge clk) disable iff (!rst_n)
    (hit_en && hit_wr) |=> mod_vec[$past(hit_idx)]);

  // R7: victim flags clear when no event hits it
  a_r7_victim_cleared: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_en && drop_en && !(hit_en && hit_idx == clr_idx))
      |=> (!use_vec[$past(clr_idx)] && !mod_vec[$past(clr_idx)]));
endmodule

// File: rtl/clock_sweeper.sv
module clock_sweeper
  import clock_victim_pkg::*;
#(
  parameter int FRAMES = 16,
  localparam int IW = $clog2(FRAMES),
  localparam int CW = $clog2(FRAMES + 2) + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [FRAMES-1:0] use_vec,
  input  logic [FRAMES-1:0] mod_vec,
  input  logic              req_valid,
  output logic              req_ready,
  output logic              vic_valid,
  input  logic              vic_ready,
  output logic [IW-1:0]     vic_frame,
  output logic              vic_dirty,
  output logic              clr_en,
  output logic [IW-1:0]     clr_idx,
  output logic              drop_en
);
  sweep_state_t state;
  logic [IW-1:0] hand, hand_nxt;
  logic [CW-1:0] sweep_cnt;
  logic          pick;

  assign hand_nxt  = (hand == IW'(FRAMES - 1)) ? '0 : hand + 1'b1;
  assign pick      = (state == ST_SWEEP) && !use_vec[hand];
  assign clr_en    = (state == ST_SWEEP);
  assign clr_idx   = hand;
  assign drop_en   = pick;
  assign req_ready = (state == ST_IDLE);
  assign vic_valid = (state == ST_HOLD);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state     <= ST_IDLE;
      hand      <= '0;
      vic_frame <= '0;
      vic_dirty <= 1'b0;
      sweep_cnt <= '0;
    end else begin
      unique case (state)
        ST_IDLE: if (req_valid) begin
          state     <= ST_SWEEP;
          sweep_cnt <= '0;
        end
        ST_SWEEP: begin
          sweep_cnt <= sweep_cnt + 1'b1;
          hand      <= hand_nxt;
          if (pick) begin
            state     <= ST_HOLD;
            vic_frame <= hand;
            vic_dirty <= mod_vec[hand];
          end
        end
        ST_HOLD: if (vic_ready) state <= ST_IDLE;
        default: state <= ST_IDLE;
      endcase
    end
  end

  // R8: a sweep never runs past FRAMES+1 examined frames
  a_r8_bounded_sweep: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_SWEEP) |-> (sweep_cnt <= CW'(FRAMES)));

  // R10: result held under back-pressure
  a_r10_hold_result: assert property (@(posedge clk) disable iff (!rst_n)
    (vic_valid && !vic_ready) |=> (vic_valid && $stable(vic_frame) && $stable(vic_dirty)));

  // R10: never accepting while a result is pending
  a_r10_excl_handshake: assert property (@(posedge clk) disable iff (!rst_n)
    !(req_ready && vic_valid));

  // R5: after a choice the hand sits one past the victim
  a_r5_hand_follows: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(vic_valid) |-> (hand == ((vic_frame == IW'(FRAMES - 1)) ? '0 : vic_frame + 1'b1)));
endmodule

// File: rtl/clock_victim_sel.sv
module clock_victim_sel #(
  parameter int FRAMES = 16,
  localparam int IW = $clog2(FRAMES)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ref_valid,
  input  logic [IW-1:0] ref_frame,
  input  logic          ref_write,
  input  logic          req_valid,
  output logic          req_ready,
  output logic          vic_valid,
  input  logic          vic_ready,
  output logic [IW-1:0] vic_frame,
  output logic          vic_dirty
);
  logic [FRAMES-1:0] use_vec, mod_vec;
  logic              clr_en, drop_en;
  logic [IW-1:0]     clr_idx;

  clock_flags #(.FRAMES(FRAMES)) u_flags (
    .clk(clk), .rst_n(rst_n),
    .hit_en(ref_valid), .hit_idx(ref_frame), .hit_wr(ref_write),
    .clr_en(clr_en), .clr_idx(clr_idx), .drop_en(drop_en),
    .use_vec(use_vec), .mod_vec(mod_vec)
  );

  clock_sweeper #(.FRAMES(FRAMES)) u_sweep (
    .clk(clk), .rst_n(rst_n),
    .use_vec(use_vec), .mod_vec(mod_vec),
    .req_valid(req_valid), .req_ready(req_ready),
    .vic_valid(vic_valid), .vic_ready(vic_ready),
    .vic_frame(vic_frame), .vic_dirty(vic_dirty),
    .clr_en(clr_en), .clr_idx(clr_idx), .drop_en(drop_en)
  );
endmodule

// File: tb/clock_victim_sel_bench.sv
module clock_victim_sel_bench;
  localparam int FRAMES = 16;
  localparam int IW = $clog2(FRAMES);

  logic clk = 1'b0, rst_n = 1'b0;
  logic ref_valid = 1'b0, ref_write = 1'b0, req_valid = 1'b0, vic_ready = 1'b0;
  logic [IW-1:0] ref_frame = '0;
  logic req_ready, vic_valid, vic_dirty;
  logic [IW-1:0] vic_frame;
  int checks = 0, errors = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  clock_victim_sel #(.FRAMES(FRAMES)) u_clock_victim_sel (
    .clk(clk), .rst_n(rst_n), .ref_valid(ref_valid), .ref_frame(ref_frame),
    .ref_write(ref_write), .req_valid(req_valid), .req_ready(req_ready),
    .vic_valid(vic_valid), .vic_ready(vic_ready), .vic_frame(vic_frame),
    .vic_dirty(vic_dirty)
  );

  // fields: use mask, write mask, victim, dirty, sweep cycles, requirement tag
  typedef struct packed {
    logic [15:0] use_m;
    logic [15:0] wr_m;
    logic [3:0]  vic;
    logic        dirty;
    logic [7:0]  cyc;
  } vec_t;
  localparam int NV = 10;
  localparam vec_t VECS [NV] = '{
    '{16'h0000, 16'h0000, 4'd0,  1'b0, 8'd1 },  // R4 empty ring
    '{16'h0006, 16'h0004, 4'd3,  1'b0, 8'd3 },  // R3 skip two
    '{16'hFFFB, 16'h0000, 4'd2,  1'b1, 8'd15},  // R6 dirty victim after wrap
    '{16'hFFFF, 16'h0008, 4'd3,  1'b1, 8'd17},  // R8 all set
    '{16'h0000, 16'h0000, 4'd4,  1'b0, 8'd1 },  // R5 hand moved
    '{16'h0020, 16'h0020, 4'd6,  1'b0, 8'd2 },  // R3
    '{16'hFFDF, 16'h0000, 4'd5,  1'b1, 8'd15},  // R6
    '{16'hFFDF, 16'h0000, 4'd5,  1'b0, 8'd16},  // R7 dirty was cleared
    '{16'h7FC0, 16'h0000, 4'd15, 1'b0, 8'd10},  // R5 last frame
    '{16'h0000, 16'h0000, 4'd0,  1'b0, 8'd1 }   // R5 wrap to zero
  };

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic refs(input logic [15:0] um, input logic [15:0] wm);
    for (int i = 0; i < FRAMES; i++) begin
      if (um[i]) begin
        @(negedge clk);
        ref_valid = 1'b1; ref_frame = IW'(i); ref_write = wm[i];
        @(posedge clk);
      end
    end
    @(negedge clk);
    ref_valid = 1'b0; ref_write = 1'b0;
  endtask

  // request; optionally reference the hand frame in the first sweep cycle
  task automatic request(input bit race, input logic [IW-1:0] race_idx,
                         output int cyc, output int fr, output int dt);
    @(negedge clk);
    req_valid = 1'b1;
    @(posedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    if (race) begin ref_valid = 1'b1; ref_frame = race_idx; ref_write = 1'b0; end
    cyc = 0;
    do begin
      @(posedge clk); cyc++;
      @(negedge clk); ref_valid = 1'b0;
    end while (!vic_valid && cyc < 100);
    fr = vic_frame; dt = vic_dirty;
    // back-pressure: hold two cycles, offer a request that must be ignored
    req_valid = 1'b1;
    repeat (2) @(negedge clk);
    check(vic_valid && vic_frame == IW'(fr) && vic_dirty == dt[0], "R10 hold", vic_frame, fr);
    check(!req_ready, "R10 busy", req_ready, 0);
    req_valid = 1'b0;
    vic_ready = 1'b1;
    @(negedge clk);
    vic_ready = 1'b0;
    check(req_ready && !vic_valid, "R10 release", req_ready, 1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check(req_ready == 1'b1, "R1 ready", req_ready, 1);
    check(vic_valid == 1'b0, "R1 valid", vic_valid, 0);

    for (int v = 0; v < NV; v++) begin
      int cyc, fr, dt;
      refs(VECS[v].use_m, VECS[v].wr_m);
      request(1'b0, '0, cyc, fr, dt);
      check(fr == int'(VECS[v].vic), "R4 victim", fr, VECS[v].vic);
      check(dt == int'(VECS[v].dirty), "R6 dirty", dt, VECS[v].dirty);
      check(cyc == int'(VECS[v].cyc), "R3 sweep cycles", cyc, VECS[v].cyc);
    end

    begin : race_test
      int cyc, fr, dt;
      // hand at 1: reference frame 1 while it is being cleared (R9)
      refs(16'h0006, 16'h0000);
      request(1'b1, IW'(1), cyc, fr, dt);
      check(fr == 3 && cyc == 3, "R9 first pass", fr, 3);
      refs(16'hFFFD, 16'h0000);
      request(1'b0, '0, cyc, fr, dt);
      check(fr == 4, "R9 flag survived", fr, 4);
      check(cyc == FRAMES + 1, "R8 full turn", cyc, FRAMES + 1);
    end

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual 1 expected 0");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule